// File: doc/BRIEF.md
# Multiframe Link Latency Counter

This block measures the receive-side latency of one serial link. It reports the latency as a phase within the local multiframe, in parallel-clock cycles. A free-running phase counter restarts on every pulse of the local multiframe boundary. Without a boundary pulse, it wraps after the number of parallel-clock cycles that make up one multiframe. That number is the multiframe length in frames divided by the number of frames carried per parallel-clock cycle.

When the receiver signals that the alignment sequence has ended and user data has begun, the phase of that cycle is latched into a held result and a valid flag is raised. Later strobes have no effect until software-independent logic pulses the re-arm input or the block is reset. The measurement is meant to be taken with any programmed link delay set to zero. Repeated captures across power cycles then give the minimum and maximum phase, from which a delay setting and a variation window are derived outside this block.

Top module: `mf_link_latency`

## Requirements
- R1: A synchronous active-high reset clears the phase counter to 0, the held latency to 0 and the valid flag to 0.
- R2: In the cycle where the boundary pulse is high, the phase is 0. In each following cycle without a boundary pulse, the phase is one more than in the previous cycle.
- R3: Without a boundary pulse, the phase wraps from CYCLES-1 to 0, where CYCLES = MF_FRAMES / FRAMES_PER_CLK. With the defaults 32 and 4, the phase runs 0 to 7 and then returns to 0.
- R4: A boundary pulse that arrives in the middle of a count restarts the phase at 0 in that cycle.
- R5: While the block is not holding a result, a strobe captures the phase of the strobe's own cycle. The captured value appears on the latency output, with valid high, in the next cycle.
- R6: While valid is high, further strobes leave the latency output and the valid flag unchanged.
- R7: A re-arm pulse drops valid in the next cycle, and a strobe in the same cycle as the re-arm is ignored. The first strobe after that captures a new value.
- R8: The latency output is ceil(log2(CYCLES)) bits wide, which is 3 bits for the defaults. MF_FRAMES must be a multiple of FRAMES_PER_CLK, and CYCLES must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| mf_tick | input | 1 | Local multiframe boundary pulse |
| data_start | input | 1 | Strobe marking the first user-data cycle after the alignment sequence |
| rearm | input | 1 | Clears the held result so the next strobe is captured |
| lat_value | output | ceil(log2(CYCLES)) | Captured phase, in parallel-clock cycles |
| lat_valid | output | 1 | High while lat_value holds a capture |

## Verification
On every cycle, the assertions check the following: the phase stays below the cycle count, it steps or wraps correctly, it restarts after a boundary pulse, the held result stays stable while valid, and re-arm or a capture moves the valid flag. Only the bench scenarios can show that the value captured equals the distance from the boundary pulse to the strobe. The bench sweeps that distance over two full multiframes, covers restarts in the middle of a count, and checks same-cycle re-arm against strobe ordering.

// File: rtl/mf_lat_pkg.sv
package mf_lat_pkg;
   function automatic int mf_cycles(input int frames, input int per_clk);
      return frames / per_clk;
   endfunction

   function automatic int phase_width(input int cycles);
      return (cycles < 2) ? 1 : $clog2(cycles);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/mf_phase_cnt.sv
module mf_phase_cnt #(
   parameter int CYCLES = 8,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         mf_tick,
   output logic [W-1:0] phase
);
   import mf_lat_pkg::*;

   logic [W-1:0] phase_q;
   logic [W-1:0] phase_nxt;

   // the boundary cycle itself reads as phase 0
   assign phase = mf_tick ? '0 : phase_q;

   generate
      if (is_pow2(CYCLES)) begin : g_pow2
         assign phase_nxt = phase + W'(1);
      end else begin : g_cmp
         assign phase_nxt = (phase == W'(CYCLES - 1)) ? '0 : phase + W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_nxt;
   end

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
      phase_q <= W'(CYCLES - 1)); // R3
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      (!mf_tick && phase_q != W'(CYCLES - 1)) |=> phase_q == $past(phase_q) + W'(1)); // R2
   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!mf_tick && phase_q == W'(CYCLES - 1)) |=> phase_q == '0); // R3
   AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
      mf_tick |=> phase_q == W'(1)); // R4
endmodule

// File: rtl/lat_capture.sv
module lat_capture #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         rearm,
   input  logic         strobe,
   input  logic [W-1:0] phase_in,
   output logic [W-1:0] value,
   output logic         valid
);
   logic take;

   assign take = strobe && !valid && !rearm;

   always_ff @(posedge clk) begin
      if (rst) begin
         value <= '0;
         valid <= 1'b0;
      end else if (rearm) begin
         valid <= 1'b0;
      end else if (take) begin
         value <= phase_in;
         valid <= 1'b1;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (valid && !rearm) |=> (valid && $stable(value))); // R6
   AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (rst)
      (!valid && strobe && !rearm) |=> (valid && value == $past(phase_in))); // R5
   AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
      rearm |=> !valid); // R7
endmodule

// File: rtl/mf_link_latency.sv
module mf_link_latency #(
   parameter int MF_FRAMES      = 32,
   parameter int FRAMES_PER_CLK = 4,
   localparam int CYCLES = mf_lat_pkg::mf_cycles(MF_FRAMES, FRAMES_PER_CLK),
   localparam int W      = mf_lat_pkg::phase_width(CYCLES)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         mf_tick,
   input  logic         data_start,
   input  logic         rearm,
   output logic [W-1:0] lat_value,
   output logic         lat_valid
);
   initial begin
      assert (FRAMES_PER_CLK > 0 && MF_FRAMES % FRAMES_PER_CLK == 0)
         else $error("MF_FRAMES must be a multiple of FRAMES_PER_CLK"); // R8
      assert (CYCLES >= 2)
         else $error("multiframe must span at least two clock cycles"); // R8
   end

   logic [W-1:0] phase;

   mf_phase_cnt #(.CYCLES(CYCLES), .W(W)) cnt_i (
      .clk(clk), .rst(rst), .mf_tick(mf_tick), .phase(phase)
   );

   lat_capture #(.W(W)) cap_i (
      .clk(clk), .rst(rst), .rearm(rearm), .strobe(data_start),
      .phase_in(phase), .value(lat_value), .valid(lat_valid)
   );

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!lat_valid && lat_value == '0)); // R1
endmodule

// File: tb/mf_link_latency_tb.sv
module mf_link_latency_tb_top;
   localparam int CYC = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mf_tick = 1'b0, data_start = 1'b0, rearm = 1'b0;
   logic [2:0] lat_value;
   logic lat_valid;
   int checks = 0, errors = 0, cyc_cnt = 0;

   always #10 clk = ~clk;

   mf_link_latency dut_i (
      .clk(clk), .rst(rst), .mf_tick(mf_tick), .data_start(data_start),
      .rearm(rearm), .lat_value(lat_value), .lat_valid(lat_valid)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_rearm();
      rearm = 1'b1; @(negedge clk); rearm = 1'b0;
   endtask

   // boundary at step 0, strobe at step d
   task automatic measure(input int d);
      for (int i = 0; i <= d; i++) begin
         mf_tick = (i == 0); data_start = (i == d);
         @(negedge clk);
      end
      mf_tick = 1'b0; data_start = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 20000) begin
         errors++; checks++;
         $display("FAIL watchdog actual %0d expected 0", cyc_cnt);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      check("R1 valid after reset", lat_valid, 0);
      check("R1 value after reset", lat_value, 0);
      check("R8 width", $bits(lat_value), 3);

      // R2 R3 R5: sweep distance over two multiframes
      for (int d = 0; d < 2 * CYC; d++) begin
         do_rearm();
         check("R7 cleared by rearm", lat_valid, 0);
         measure(d);
         check("R5 valid", lat_valid, 1);
         check(d >= CYC ? "R3 wrapped phase" : "R2 phase", lat_value, d % CYC);
      end

      // R6: later strobes ignored
      do_rearm(); measure(5);
      for (int k = 0; k < 4; k++) begin
         data_start = 1'b1; @(negedge clk); data_start = 1'b0; @(negedge clk);
         check("R6 held value", lat_value, 5);
         check("R6 held valid", lat_valid, 1);
      end

      // R4: mid-count restart
      do_rearm();
      mf_tick = 1'b1; @(negedge clk); mf_tick = 1'b0;
      repeat (4) @(negedge clk);
      measure(3);
      check("R4 restart", lat_value, 3);

      // R7: strobe coinciding with rearm ignored
      rearm = 1'b1; data_start = 1'b1; @(negedge clk);
      rearm = 1'b0; data_start = 1'b0;
      check("R7 same-cycle strobe ignored", lat_valid, 0);
      @(negedge clk);
      check("R7 still idle", lat_valid, 0);
      measure(6);
      check("R7 new capture", lat_value, 6);
      check("R7 new valid", lat_valid, 1);

      // R1: mid-run reset
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      check("R1 valid cleared", lat_valid, 0);
      check("R1 value cleared", lat_value, 0);
      // counter cleared: strobe in first cycle after reset reads phase 0
      data_start = 1'b1; @(negedge clk); data_start = 1'b0;
      check("R1 counter cleared", lat_value, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule